// File: doc/BRIEF.md
# Segment Limit and Rights Checker

This block decides whether one memory access through a segment must raise a general-protection fault. The access is described by its linear address, the segment base and limit, its size and its kind (read, write or fetch), and by the segment's attribute bits. It also receives two selector flags: one saying that the selector is null and one saying that the segment is exempt from the null check. The code-segment default-size bit and an address-size override bit choose a 16-bit or a 32-bit effective offset. A long-mode flag turns every check off.

The verdict is computed in one combinational pass and captured in a register. A two-state controller marks when that register holds a fresh result. The controller has two states. `ST_IDLE` holds no result. `ST_RESULT` holds the verdict of the access strobed on the previous cycle. The transition `GO_RESULT` is taken on any cycle with `in_valid` high, from either state. The transition `GO_IDLE` is taken on any cycle with `in_valid` low. Reset forces `ST_IDLE`.

Top module: `seg_guard`

## Requirements
- R1: When `long_mode` is 1, the reported result is never a fault, whatever the other inputs are.
- R2: Outside long mode, `sel_null`=1 together with `sel_exempt`=0 raises a fault. With `sel_exempt`=1 the null flag has no effect.
- R3: Outside long mode, with `attr_data`=1, the following raise a fault: a write (`acc_kind`=01) when `attr_wr`=0, and a read (`acc_kind`=00) when `attr_rd`=0. A fetch (`acc_kind`=10 or 11) raises no rights fault, and a segment with `attr_data`=0 raises no rights fault.
- R4: The effective offset width is 16 bits when `cs_dsize` equals `asz_ovr`, and 32 bits when they differ.
- R5: The offset is (`lin_addr` − `seg_base`) modulo 2^width. The access size is 2^`size_log2` bytes (00=1, 01=2, 10=4, 11=8). The end offset is offset + size − 1, computed without wrap-around.
- R6: For a segment that is not expand-down, a fault is raised if the offset or the end offset is greater than `seg_limit`.
- R7: Expand-down applies only when `attr_data`=1 and `attr_xdown`=1. In that case a fault is raised if the offset or the end offset is less than or equal to `seg_limit`.
- R8: `out_valid` is high exactly one cycle after a cycle with `in_valid` high, and at no other time. `gp_fault` is low whenever `out_valid` is low, including after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Access strobe |
| lin_addr | input | 32 | Linear address of the access |
| seg_base | input | 32 | Segment base |
| seg_limit | input | 32 | Segment limit |
| size_log2 | input | 2 | log2 of access size in bytes |
| acc_kind | input | 2 | 00 read, 01 write, 10/11 fetch |
| attr_rd | input | 1 | Segment readable |
| attr_wr | input | 1 | Segment writable |
| attr_xdown | input | 1 | Segment expands downward |
| attr_data | input | 1 | Segment is of data class |
| cs_dsize | input | 1 | Code segment default-size bit |
| asz_ovr | input | 1 | Address-size override |
| sel_null | input | 1 | Selector is null |
| sel_exempt | input | 1 | Segment exempt from null check |
| long_mode | input | 1 | 64-bit mode, checks skipped |
| out_valid | output | 1 | Result present |
| gp_fault | output | 1 | General-protection fault verdict |

## Verification
The bench sweeps offsets from nine bytes below to nine bytes above several limits. The sweep covers every size, both limit senses and all four width selections, so that off-by-one errors at the limit show up. A checker that compared only the first byte would accept 8-byte accesses that straddle the limit. A checker that used `<` in place of `<=` on expand-down segments would accept an access that lands exactly on the limit. A base above the address makes the subtraction wrap. A design that forgot to truncate to 16 bits would then see a huge offset. A design that picked the width from the wrong parity of the two bits would fault on an access that is in range. The rights sweep crosses every attribute with every access kind, the null and exempt flags, and long mode. A design that applied the rights check to fetches, or to segments outside the data class, would then report faults that should not exist.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;

    typedef enum logic [1:0] {
        ACC_READ      = 2'b00,
        ACC_WRITE     = 2'b01,
        ACC_FETCH     = 2'b10,
        ACC_FETCH_ALT = 2'b11
    } acc_kind_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } guard_state_e;

endpackage

// File: rtl/seg_offset_calc.sv
module seg_offset_calc #(
    parameter int ADDR_W   = 32,
    parameter int NARROW_W = 16,
    parameter int SIZE_W   = 2
) (
    input  logic [ADDR_W-1:0] lin_addr,
    input  logic [ADDR_W-1:0] seg_base,
    input  logic [SIZE_W-1:0] size_log2,
    input  logic              narrow,
    output logic [ADDR_W-1:0] offset,
    output logic [ADDR_W:0]   end_offset
);
    localparam int EXT_W = ADDR_W + 1;

    logic [ADDR_W-1:0] diff;
    logic [ADDR_W-1:0] keep_mask;
    logic [EXT_W-1:0]  nbytes;

    assign diff = lin_addr - seg_base;

    // Bits below NARROW_W are always kept; the rest only in the wide width.
    genvar gi;
    generate
        for (gi = 0; gi < ADDR_W; gi++) begin : g_mask
            if (gi < NARROW_W) begin : g_low
                assign keep_mask[gi] = 1'b1;
            end else begin : g_high
                assign keep_mask[gi] = ~narrow;
            end
        end
    endgenerate

    always_comb begin
        offset     = diff & keep_mask;
        nbytes     = EXT_W'(1) << size_log2;
        end_offset = {1'b0, offset} + nbytes - EXT_W'(1);
    end
endmodule

// File: rtl/seg_bound_cmp.sv
module seg_bound_cmp #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] offset,
    input  logic [ADDR_W:0]   end_offset,
    input  logic [ADDR_W-1:0] seg_limit,
    input  logic              expand_down,
    output logic              bound_viol
);
    logic [ADDR_W:0] lim_ext;
    logic [ADDR_W:0] off_ext;
    logic            first_above;
    logic            last_above;

    always_comb begin
        lim_ext     = {1'b0, seg_limit};
        off_ext     = {1'b0, offset};
        first_above = off_ext > lim_ext;
        last_above  = end_offset > lim_ext;
        if (expand_down) begin
            bound_viol = !first_above || !last_above;
        end else begin
            bound_viol = first_above || last_above;
        end
    end
endmodule

// File: rtl/seg_rights_chk.sv
module seg_rights_chk
    import seg_guard_pkg::*;
(
    input  logic [1:0] acc_kind,
    input  logic       attr_rd,
    input  logic       attr_wr,
    input  logic       attr_data,
    input  logic       sel_null,
    input  logic       sel_exempt,
    output logic       rights_viol
);
    acc_kind_e kind;
    logic      null_viol;
    logic      kind_viol;

    always_comb begin
        kind      = acc_kind_e'(acc_kind);
        null_viol = sel_null && !sel_exempt;
        kind_viol = 1'b0;
        if (attr_data) begin
            unique case (kind)
                ACC_READ:      kind_viol = !attr_rd;
                ACC_WRITE:     kind_viol = !attr_wr;
                ACC_FETCH,
                ACC_FETCH_ALT: kind_viol = 1'b0;
                default:       kind_viol = 1'b0;
            endcase
        end
        rights_viol = null_viol || kind_viol;
    end
endmodule

// File: rtl/seg_guard.sv
module seg_guard
    import seg_guard_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int NARROW_W = 16,
    parameter int SIZE_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] lin_addr,
    input  logic [ADDR_W-1:0] seg_base,
    input  logic [ADDR_W-1:0] seg_limit,
    input  logic [SIZE_W-1:0] size_log2,
    input  logic [1:0]        acc_kind,
    input  logic              attr_rd,
    input  logic              attr_wr,
    input  logic              attr_xdown,
    input  logic              attr_data,
    input  logic              cs_dsize,
    input  logic              asz_ovr,
    input  logic              sel_null,
    input  logic              sel_exempt,
    input  logic              long_mode,
    output logic              out_valid,
    output logic              gp_fault
);
    logic              narrow;
    logic              xdown_eff;
    logic [ADDR_W-1:0] offset;
    logic [ADDR_W:0]   end_offset;
    logic              bound_viol;
    logic              rights_viol;
    logic              fault_d;
    logic              fault_q;
    guard_state_e      state_q;
    guard_state_e      state_d;

    assign narrow    = (cs_dsize == asz_ovr);
    assign xdown_eff = attr_data && attr_xdown;

    seg_offset_calc #(
        .ADDR_W   (ADDR_W),
        .NARROW_W (NARROW_W),
        .SIZE_W   (SIZE_W)
    ) u_offset (
        .lin_addr   (lin_addr),
        .seg_base   (seg_base),
        .size_log2  (size_log2),
        .narrow     (narrow),
        .offset     (offset),
        .end_offset (end_offset)
    );

    seg_bound_cmp #(
        .ADDR_W (ADDR_W)
    ) u_bound (
        .offset      (offset),
        .end_offset  (end_offset),
        .seg_limit   (seg_limit),
        .expand_down (xdown_eff),
        .bound_viol  (bound_viol)
    );

    seg_rights_chk u_rights (
        .acc_kind    (acc_kind),
        .attr_rd     (attr_rd),
        .attr_wr     (attr_wr),
        .attr_data   (attr_data),
        .sel_null    (sel_null),
        .sel_exempt  (sel_exempt),
        .rights_viol (rights_viol)
    );

    assign fault_d = !long_mode && (rights_viol || bound_viol);

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = in_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fault_q <= 1'b0;
        end else begin
            state_q <= state_d;
            fault_q <= in_valid && fault_d;
        end
    end

    always_comb begin
        out_valid = 1'b0;
        gp_fault  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                out_valid = 1'b0;
                gp_fault  = 1'b0;
            end
            ST_RESULT: begin
                out_valid = 1'b1;
                gp_fault  = fault_q;
            end
            default: begin
                out_valid = 1'b0;
                gp_fault  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/seg_guard_chk.sv
module seg_guard_chk #(
    parameter int ADDR_W = 32
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [1:0] acc_kind,
    input logic       attr_wr,
    input logic       attr_data,
    input logic       sel_null,
    input logic       sel_exempt,
    input logic       long_mode,
    input logic       out_valid,
    input logic       gp_fault
);
    a_r1_longmode_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && long_mode) |=> !gp_fault);

    a_r2_null_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !long_mode && sel_null && !sel_exempt) |=> gp_fault);

    a_r3_write_protect: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !long_mode && attr_data && acc_kind == 2'b01 && !attr_wr)
        |=> gp_fault);

    a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r8_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r8_fault_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !gp_fault);
endmodule

bind seg_guard seg_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .acc_kind   (acc_kind),
    .attr_wr    (attr_wr),
    .attr_data  (attr_data),
    .sel_null   (sel_null),
    .sel_exempt (sel_exempt),
    .long_mode  (long_mode),
    .out_valid  (out_valid),
    .gp_fault   (gp_fault)
);

// File: tb/seg_guard_bench.sv
module seg_guard_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] lin_addr = '0;
    logic [31:0] seg_base = '0;
    logic [31:0] seg_limit = '0;
    logic [1:0]  size_log2 = '0;
    logic [1:0]  acc_kind = '0;
    logic        attr_rd = 1'b1;
    logic        attr_wr = 1'b1;
    logic        attr_xdown = 1'b0;
    logic        attr_data = 1'b1;
    logic        cs_dsize = 1'b0;
    logic        asz_ovr = 1'b1;
    logic        sel_null = 1'b0;
    logic        sel_exempt = 1'b0;
    logic        long_mode = 1'b0;
    logic        out_valid;
    logic        gp_fault;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    seg_guard u_seg_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .lin_addr   (lin_addr),
        .seg_base   (seg_base),
        .seg_limit  (seg_limit),
        .size_log2  (size_log2),
        .acc_kind   (acc_kind),
        .attr_rd    (attr_rd),
        .attr_wr    (attr_wr),
        .attr_xdown (attr_xdown),
        .attr_data  (attr_data),
        .cs_dsize   (cs_dsize),
        .asz_ovr    (asz_ovr),
        .sel_null   (sel_null),
        .sel_exempt (sel_exempt),
        .long_mode  (long_mode),
        .out_valid  (out_valid),
        .gp_fault   (gp_fault)
    );

    function automatic bit model();
        logic [31:0] diff;
        logic [31:0] off;
        logic [32:0] last;
        if (long_mode) return 1'b0;
        if (sel_null && !sel_exempt) return 1'b1;
        if (attr_data && acc_kind == 2'b01 && !attr_wr) return 1'b1;
        if (attr_data && acc_kind == 2'b00 && !attr_rd) return 1'b1;
        diff = lin_addr - seg_base;
        off  = (cs_dsize == asz_ovr) ? (diff % 32'h1_0000) : diff;
        last = 33'(off) + (33'd1 << size_log2) - 33'd1;
        if (attr_data && attr_xdown)
            return (33'(off) <= 33'(seg_limit)) || (last <= 33'(seg_limit));
        return (33'(off) > 33'(seg_limit)) || (last > 33'(seg_limit));
    endfunction

    // Inputs are already set at a falling edge; result is checked one cycle later.
    task automatic run_one(input string tag);
        bit exp;
        exp = model();
        in_valid = 1'b1;
        @(negedge clk);
        tests++;
        if (out_valid !== 1'b1 || gp_fault !== exp) begin
            fails++;
            $display("FAIL %s: got valid=%0b fault=%0b expected valid=1 fault=%0b addr=%h base=%h lim=%h",
                     tag, out_valid, gp_fault, exp, lin_addr, seg_base, seg_limit);
        end
        in_valid = 1'b0;
    endtask

    task automatic check_idle(input string tag);
        in_valid = 1'b0;
        @(negedge clk);
        tests++;
        if (out_valid !== 1'b0 || gp_fault !== 1'b0) begin
            fails++;
            $display("FAIL %s: got valid=%0b fault=%0b expected valid=0 fault=0",
                     tag, out_valid, gp_fault);
        end
    endtask

    task automatic set_benign();
        attr_rd = 1'b1; attr_wr = 1'b1; attr_data = 1'b1; attr_xdown = 1'b0;
        sel_null = 1'b0; sel_exempt = 1'b0; long_mode = 1'b0;
        acc_kind = 2'b00; cs_dsize = 1'b1; asz_ovr = 1'b0;
        seg_base = 32'h0000_1000; seg_limit = 32'hFFFF_FFF0;
        lin_addr = 32'h0000_2000; size_log2 = 2'd2;
    endtask

    initial begin
        logic [31:0] lims [4];
        lims[0] = 32'h0000_0000; lims[1] = 32'h0000_00FF;
        lims[2] = 32'h0000_FFFF; lims[3] = 32'h1234_5678;

        repeat (3) @(negedge clk);
        tests++;
        if (out_valid !== 1'b0 || gp_fault !== 1'b0) begin
            fails++;
            $display("FAIL R8 reset: got valid=%0b fault=%0b expected valid=0 fault=0",
                     out_valid, gp_fault);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R8 idle after reset");

        // R6 / R7: limit sweep across widths, sizes and limit sense
        set_benign();
        for (int w = 0; w < 4; w++) begin
            for (int xd = 0; xd < 2; xd++) begin
                for (int sz = 0; sz < 4; sz++) begin
                    for (int li = 0; li < 4; li++) begin
                        for (int d = -9; d <= 9; d++) begin
                            cs_dsize   = w[1];
                            asz_ovr    = w[0];
                            attr_xdown = xd[0];
                            size_log2  = sz[1:0];
                            seg_limit  = lims[li];
                            lin_addr   = seg_base + lims[li] + 32'(d);
                            run_one(xd != 0 ? "R7 expand-down sweep" : "R6 normal sweep");
                        end
                    end
                end
            end
        end
        check_idle("R8 gap between strobes");

        // R7: expand-down ignored for non-data segments
        set_benign();
        attr_data = 1'b0; attr_xdown = 1'b1; seg_limit = 32'h100;
        lin_addr = seg_base + 32'h80;
        run_one("R7 xdown ignored off data class");

        // R4: width selection decides whether high bits count
        set_benign();
        seg_base = 32'h0; seg_limit = 32'h10; lin_addr = 32'h0001_0005; size_log2 = 2'd0;
        for (int w = 0; w < 4; w++) begin
            cs_dsize = w[1]; asz_ovr = w[0];
            run_one("R4 width select");
        end

        // R5: base above address wraps, narrow truncation; size straddle
        set_benign();
        seg_base = 32'h0003_0010; lin_addr = 32'h0001_0000; seg_limit = 32'h0000_FFF8;
        for (int w = 0; w < 4; w++) begin
            for (int sz = 0; sz < 4; sz++) begin
                cs_dsize = w[1]; asz_ovr = w[0]; size_log2 = sz[1:0];
                run_one("R5 wrapped offset");
            end
        end
        set_benign();
        seg_limit = 32'h0000_0100; lin_addr = seg_base + 32'hFA; size_log2 = 2'd3;
        run_one("R5 last byte past limit");
        size_log2 = 2'd2;
        run_one("R5 last byte inside limit");

        // R1 / R2 / R3: rights, null and long mode crossed
        for (int v = 0; v < 512; v++) begin
            set_benign();
            attr_rd    = v[0];
            attr_wr    = v[1];
            attr_data  = v[2];
            acc_kind   = v[4:3];
            sel_null   = v[5];
            sel_exempt = v[6];
            long_mode  = v[7];
            if (v[8]) begin
                seg_limit = 32'h0;
                lin_addr  = seg_base + 32'h40;
            end
            if (long_mode) run_one("R1 long mode clean");
            else if (sel_null) run_one("R2 null selector");
            else run_one("R3 rights check");
        end
        check_idle("R8 final idle");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule